// File: doc/BRIEF.md
# ADC Measurement Timing Scheduler

This block paces the conversion requests sent to a multiplexed analog-to-digital converter. After a start pulse it waits a programmable settling time so the input multiplexer output can stabilise. It then requests a burst of conversions, one at a time, and accumulates the returned samples. The average of the burst is reported as a single result word. In single mode the block then returns to idle. In continuous mode it waits a programmable measurement interval, settles again and repeats, until a stop pulse arrives.

Three time bases are derived from the system clock by elaboration-time divider parameters: a 100 us tick and a 2 ms tick for settling, and a 32768 Hz tick for the interval. Settle, interval, averaging and mode settings are captured when a measurement run starts. Samples enter on a valid/ready handshake. `samp_ready` is high only while the block waits for the sample of the conversion it last requested. A sample is taken on a cycle where both `samp_valid` and `samp_ready` are high. `samp_valid` may be held high for any length of time without effect while `samp_ready` is low. The result output cannot be held off: `res_valid` is a single-cycle pulse and the consumer must capture `res_data` in that cycle.

Top module: `adc_meas_sched`

## Requirements
- R1: While reset is asserted and right after it is released, `busy`, `conv_start`, `samp_ready` and `res_valid` are all low.
- R2: The settle code k (4 bits) selects a delay of k ticks of the 100 us base for k up to 10, and (k-10) ticks of the 2 ms base for k of 11 and above. If start is high in cycle c, the first `conv_start` pulse is high in cycle c + D + 2, where D is the settle delay in clock cycles.
- R3: A measurement issues exactly 2^N one-cycle `conv_start` pulses. Each pulse after the first follows the acceptance of the previous sample.
- R4: `res_data` equals the sum of the 2^N accepted samples shifted right by N (floor). `res_valid` is high for one cycle, in the cycle after the last sample is accepted. There is no overflow, even with full-scale samples.
- R5: An averaging code above 9 behaves as code 9 (512 conversions).
- R6: In single mode (`cont_mode` = 0) exactly one result is produced, and then `busy` falls.
- R7: In continuous mode, interval code 0 adds no wait, and code j > 0 waits 2^(j+4) ticks of the 32768 Hz base. The next `conv_start` follows the previous `res_valid` cycle by I + D + 2 cycles, where I is the interval in clock cycles. `busy` stays high.
- R8: A stop pulse aborts any settle wait, interval wait or burst. `busy` is low in the next cycle and no result is produced for the aborted measurement. Stop takes priority over start.
- R9: `samp_valid` while `samp_ready` is low does not affect the result.
- R10: Start while busy is ignored. Codes are captured at start, so changing the code inputs during a run has no effect on it.
- R11: The accumulator starts from zero for every measurement, including after an aborted burst and between continuous repetitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a measurement run (pulse, ignored while busy) |
| stop | input | 1 | Abort the run and return to idle |
| cont_mode | input | 1 | 0: single measurement, 1: repeat every interval |
| settle_code | input | 4 | Settle delay code |
| gap_code | input | 4 | Measurement interval code |
| avg_code | input | 4 | log2 of the number of conversions per result (clamped to 9) |
| conv_start | output | 1 | One-cycle request for a conversion |
| samp_valid | input | 1 | Converter sample available |
| samp_ready | output | 1 | Block accepts a sample this cycle |
| samp_data | input | SAMP_W | Converter sample word |
| busy | output | 1 | A run is in progress |
| res_valid | output | 1 | One-cycle pulse marking a new averaged result |
| res_data | output | SAMP_W | Averaged result |

## Verification
The assertions assume that the converter presents a sample only in response to a conversion request. They also assume that the divider parameters are at least one, so every tick base advances. The bench's converter model raises `samp_valid` with fresh data only in cycles where it sees `samp_ready`, except in one deliberate test that drives spurious valids during settling. Start and stop are driven as single-cycle pulses, away from the clock edge. Interval codes stay small enough that continuous runs finish within the bench's time limit.

// File: rtl/adc_sched_pkg.sv
package adc_sched_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_ISSUE,
    ST_WAIT,
    ST_GAP
  } sched_state_t;

  localparam int unsigned TICK_W = 20;

  // Number of base ticks for a settle code (fine base below 11, coarse above)
  function automatic logic [TICK_W-1:0] settle_ticks(input logic [3:0] code);
    if (code < 4'd11) return TICK_W'(code);
    else              return TICK_W'(code - 4'd10);
  endfunction

  function automatic logic settle_is_coarse(input logic [3:0] code);
    return (code >= 4'd11);
  endfunction

  // Number of slow ticks for an interval code: none for 0, else 2^(code+4)
  function automatic logic [TICK_W-1:0] gap_ticks(input logic [3:0] code);
    if (code == 4'd0) return '0;
    else              return TICK_W'(1) << (int'(code) + 4);
  endfunction

endpackage

// File: rtl/adc_wait_timer.sv
module adc_wait_timer #(
  parameter int unsigned TICK_W = 20,
  parameter int unsigned DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TICK_W-1:0] ticks,
  input  logic [DIV_W-1:0]  div,
  output logic              expired
);

  logic [TICK_W-1:0] remain_q;
  logic [DIV_W-1:0]  pre_q;
  logic [DIV_W-1:0]  div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      pre_q    <= '0;
      div_q    <= DIV_W'(1);
    end else if (load) begin
      remain_q <= ticks;
      pre_q    <= div - DIV_W'(1);
      div_q    <= div;
    end else if (remain_q != '0) begin
      if (pre_q == '0) begin
        remain_q <= remain_q - TICK_W'(1);
        pre_q    <= div_q - DIV_W'(1);
      end else begin
        pre_q <= pre_q - DIV_W'(1);
      end
    end
  end

  assign expired = (remain_q == '0);

  // R2
  hold_expired_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);

  // R2
  load_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (remain_q == $past(ticks)));

endmodule

// File: rtl/adc_avg_accum.sv
module adc_avg_accum #(
  parameter int unsigned SAMP_W   = 12,
  parameter int unsigned MAX_LOG2 = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic [$clog2(MAX_LOG2+1)-1:0] log2n,
  input  logic                        take,
  input  logic [SAMP_W-1:0]           sample,
  output logic                        last,
  output logic [SAMP_W-1:0]           avg_out
);

  localparam int unsigned ACC_W = SAMP_W + MAX_LOG2;
  localparam int unsigned CNT_W = MAX_LOG2 + 1;

  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] total;
  logic [ACC_W-1:0] sum_next;

  assign total    = CNT_W'(1) << log2n;
  assign last     = (cnt_q == total - CNT_W'(1));
  assign sum_next = acc_q + ACC_W'(sample);
  assign avg_out  = SAMP_W'(sum_next >> log2n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clear || (take && last)) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (take) begin
      acc_q <= sum_next;
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < total);

  // R11
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc_q == '0 && cnt_q == '0));

endmodule

// File: rtl/adc_meas_sched.sv
module adc_meas_sched
  import adc_sched_pkg::*;
#(
  parameter int unsigned SAMP_W       = 12,
  parameter int unsigned MAX_AVG_LOG2 = 9,
  parameter int unsigned DIV_100US    = 1920,
  parameter int unsigned DIV_2MS      = 38400,
  parameter int unsigned DIV_SLOW     = 586
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              stop,
  input  logic              cont_mode,
  input  logic [3:0]        settle_code,
  input  logic [3:0]        gap_code,
  input  logic [3:0]        avg_code,
  output logic              conv_start,
  input  logic              samp_valid,
  output logic              samp_ready,
  input  logic [SAMP_W-1:0] samp_data,
  output logic              busy,
  output logic              res_valid,
  output logic [SAMP_W-1:0] res_data
);

  localparam int unsigned LOG2_W  = $clog2(MAX_AVG_LOG2 + 1);
  localparam int unsigned DIV_MAX = (DIV_100US > DIV_2MS)
                                    ? ((DIV_100US > DIV_SLOW) ? DIV_100US : DIV_SLOW)
                                    : ((DIV_2MS > DIV_SLOW) ? DIV_2MS : DIV_SLOW);
  localparam int unsigned DIV_W   = $clog2(DIV_MAX + 1);

  sched_state_t state_q, state_d;

  logic [3:0]        settle_q, gap_q;
  logic [LOG2_W-1:0] avg_q, avg_clamped;
  logic              cont_q;

  logic              tmr_load;
  logic [TICK_W-1:0] tmr_ticks;
  logic [DIV_W-1:0]  tmr_div;
  logic              tmr_expired;

  logic              acc_clear;
  logic              take;
  logic              acc_last;
  logic [SAMP_W-1:0] acc_avg;

  logic [3:0]        settle_src;
  logic              launch;

  assign avg_clamped = (avg_code > 4'(MAX_AVG_LOG2)) ? LOG2_W'(MAX_AVG_LOG2)
                                                     : LOG2_W'(avg_code);
  assign launch      = (state_q == ST_IDLE) && start && !stop;
  assign settle_src  = (state_q == ST_IDLE) ? settle_code : settle_q;
  assign take        = (state_q == ST_WAIT) && samp_valid && !stop;

  // Next state and timer loading
  always_comb begin
    state_d   = state_q;
    tmr_load  = 1'b0;
    tmr_ticks = settle_ticks(settle_src);
    tmr_div   = settle_is_coarse(settle_src) ? DIV_W'(DIV_2MS) : DIV_W'(DIV_100US);
    acc_clear = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (launch) begin
          state_d   = ST_SETTLE;
          tmr_load  = 1'b1;
          acc_clear = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (tmr_expired) state_d = ST_ISSUE;
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (take) begin
          if (!acc_last) begin
            state_d = ST_ISSUE;
          end else if (cont_q) begin
            state_d   = ST_GAP;
            tmr_load  = 1'b1;
            tmr_ticks = gap_ticks(gap_q);
            tmr_div   = DIV_W'(DIV_SLOW);
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_GAP: begin
        if (tmr_expired) begin
          state_d   = ST_SETTLE;
          tmr_load  = 1'b1;
          acc_clear = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (stop) begin
      state_d  = ST_IDLE;
      tmr_load = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      settle_q <= '0;
      gap_q    <= '0;
      avg_q    <= '0;
      cont_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (launch) begin
        settle_q <= settle_code;
        gap_q    <= gap_code;
        avg_q    <= avg_clamped;
        cont_q   <= cont_mode;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= take && acc_last;
      if (take && acc_last) res_data <= acc_avg;
    end
  end

  adc_wait_timer #(
    .TICK_W (TICK_W),
    .DIV_W  (DIV_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .ticks   (tmr_ticks),
    .div     (tmr_div),
    .expired (tmr_expired)
  );

  adc_avg_accum #(
    .SAMP_W   (SAMP_W),
    .MAX_LOG2 (MAX_AVG_LOG2)
  ) u_accum (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (acc_clear),
    .log2n   (avg_q),
    .take    (take),
    .sample  (samp_data),
    .last    (acc_last),
    .avg_out (acc_avg)
  );

  assign conv_start = (state_q == ST_ISSUE);
  assign samp_ready = (state_q == ST_WAIT);
  assign busy       = (state_q != ST_IDLE);

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!busy && !res_valid));

  // R4
  res_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(samp_valid && samp_ready));

  // R5
  avg_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avg_q <= LOG2_W'(MAX_AVG_LOG2));

  // R3
  req_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !stop) |=> samp_ready);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !stop) |=> ($stable(settle_q) && $stable(avg_q) && $stable(cont_q)));

endmodule

// File: tb/adc_meas_sched_tb.sv
module adc_meas_sched_tb;

  localparam int SAMP_W = 12;
  localparam int D100   = 2;
  localparam int D2M    = 5;
  localparam int DSLOW  = 1;
  localparam int NV     = 8;

  // vector bits: [13] cont, [12:9] settle, [8:5] gap, [4:1] avg, [0] full-scale samples
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 4'd0,  4'd0, 4'd0,  1'b0},
    {1'b0, 4'd3,  4'd0, 4'd2,  1'b0},
    {1'b0, 4'd11, 4'd0, 4'd4,  1'b1},
    {1'b0, 4'd15, 4'd0, 4'd3,  1'b0},
    {1'b1, 4'd1,  4'd0, 4'd1,  1'b0},
    {1'b1, 4'd10, 4'd2, 4'd2,  1'b0},
    {1'b0, 4'd2,  4'd0, 4'd9,  1'b1},
    {1'b0, 4'd4,  4'd0, 4'd12, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, cont_mode = 1'b0;
  logic [3:0] settle_code = '0, gap_code = '0, avg_code = '0;
  logic conv_start, samp_ready, busy, res_valid;
  logic samp_valid;
  logic [SAMP_W-1:0] samp_data, res_data;

  always #10 clk = ~clk;

  adc_meas_sched #(
    .SAMP_W(SAMP_W), .MAX_AVG_LOG2(9),
    .DIV_100US(D100), .DIV_2MS(D2M), .DIV_SLOW(DSLOW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .cont_mode(cont_mode),
    .settle_code(settle_code), .gap_code(gap_code), .avg_code(avg_code),
    .conv_start(conv_start), .samp_valid(samp_valid), .samp_ready(samp_ready),
    .samp_data(samp_data), .busy(busy), .res_valid(res_valid), .res_data(res_data)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // monitor / converter model state
  int cyc = 0, nconv = 0, mi = 0, cur_n = 0;
  longint sum = 0;
  bit full_pat = 0, junk = 0;
  logic [15:0] lcg = 16'hACE1;
  int first_conv [4];
  int res_c [4];
  int ncv [4];
  int res_v [4];
  int exp_v [4];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int settle_cyc(input int k);
    return (k < 11) ? k * D100 : (k - 10) * D2M;
  endfunction

  function automatic int gap_cyc(input int j);
    return (j == 0) ? 0 : (1 << (j + 4)) * DSLOW;
  endfunction

  // converter model and event monitor, acting at the falling edge
  initial begin
    samp_valid = 1'b0;
    samp_data  = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (conv_start) begin
        if (nconv == 0 && mi < 4) first_conv[mi] = cyc;
        nconv++;
      end
      if (res_valid) begin
        if (mi < 4) begin
          res_v[mi] = int'(res_data);
          exp_v[mi] = int'(sum >> cur_n);
          ncv[mi]   = nconv;
          res_c[mi] = cyc;
        end
        mi++;
        nconv = 0;
        sum = 0;
      end
      if (samp_ready) begin
        samp_valid = 1'b1;
        samp_data  = full_pat ? {SAMP_W{1'b1}} : lcg[SAMP_W-1:0];
        sum += longint'(samp_data);
        lcg = {lcg[14:0], lcg[15] ^ lcg[13] ^ lcg[12] ^ lcg[10]};
      end else if (junk) begin
        samp_valid = 1'b1;
        samp_data  = {SAMP_W{1'b1}};
      end else begin
        samp_valid = 1'b0;
      end
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic clear_mon();
    nconv = 0; mi = 0; sum = 0;
    for (int i = 0; i < 4; i++) begin
      first_conv[i] = -1; res_c[i] = -1; ncv[i] = -1; res_v[i] = -1; exp_v[i] = -2;
    end
  endtask

  // pulse start for one cycle; returns the stamp of the start cycle
  task automatic kick(output int t0);
    step(1);
    start = 1'b1;
    t0 = cyc + 1;
    step(1);
    start = 1'b0;
  endtask

  task automatic pulse_stop();
    stop = 1'b1;
    step(1);
    stop = 1'b0;
  endtask

  task automatic wait_res(input int need);
    int w = 0;
    while (mi < need && w < 20000) begin
      step(1);
      w++;
    end
  endtask

  initial begin
    int t0;
    clear_mon();
    // R1 during reset
    step(3);
    chk(!busy && !conv_start && !samp_ready && !res_valid, "R1", "outputs in reset",
        {busy, conv_start, samp_ready, res_valid}, 0);
    rst_n = 1'b1;
    step(2);
    chk(!busy && !conv_start && !samp_ready && !res_valid, "R1", "outputs after reset",
        {busy, conv_start, samp_ready, res_valid}, 0);

    // table-driven runs
    for (int v = 0; v < NV; v++) begin
      int k, j, a, s, g;
      logic c;
      c = VEC[v][13];
      k = int'(VEC[v][12:9]);
      j = int'(VEC[v][8:5]);
      a = int'(VEC[v][4:1]);
      full_pat = VEC[v][0];
      s = settle_cyc(k);
      g = gap_cyc(j);
      clear_mon();
      cur_n = (a > 9) ? 9 : a;
      cont_mode = c; settle_code = 4'(k); gap_code = 4'(j); avg_code = 4'(a);
      kick(t0);
      if (!c) begin
        wait_res(1);
        step(3);
        chk(mi == 1, "R6", "single-mode result count", mi, 1);
        chk(!busy, "R6", "busy after single run", busy, 0);
        chk(ncv[0] == (1 << cur_n), (a > 9) ? "R5" : "R3", "conversions per result",
            ncv[0], 1 << cur_n);
        chk(res_v[0] == exp_v[0], "R4", "averaged result", res_v[0], exp_v[0]);
        chk(first_conv[0] - t0 == s + 2, "R2", "settle latency", first_conv[0] - t0, s + 2);
      end else begin
        wait_res(2);
        chk(busy, "R7", "busy in continuous mode", busy, 1);
        chk(first_conv[1] - res_c[0] == g + s + 2, "R7", "interval spacing",
            first_conv[1] - res_c[0], g + s + 2);
        chk(res_v[0] == exp_v[0], "R4", "first continuous result", res_v[0], exp_v[0]);
        chk(res_v[1] == exp_v[1], "R11", "second continuous result", res_v[1], exp_v[1]);
        chk(ncv[1] == (1 << cur_n), "R3", "conversions in repeat", ncv[1], 1 << cur_n);
        pulse_stop();
        chk(!busy, "R8", "busy after stop in continuous", busy, 0);
        step(5);
      end
    end
    full_pat = 1'b0;

    // R8 stop during settling
    clear_mon();
    cont_mode = 1'b0; settle_code = 4'd15; avg_code = 4'd0; cur_n = 0;
    kick(t0);
    step(5);
    pulse_stop();
    chk(!busy, "R8", "busy after stop in settle", busy, 0);
    step(40);
    chk(nconv == 0 && mi == 0, "R8", "activity after stop in settle", nconv + mi, 0);

    // R8 stop during burst, then R11 clean next measurement
    clear_mon();
    settle_code = 4'd0; avg_code = 4'd5; cur_n = 5;
    kick(t0);
    begin
      int w = 0;
      while (nconv < 10 && w < 1000) begin step(1); w++; end
    end
    pulse_stop();
    chk(!busy, "R8", "busy after stop in burst", busy, 0);
    step(20);
    chk(mi == 0, "R8", "result after aborted burst", mi, 0);
    clear_mon();
    avg_code = 4'd2; cur_n = 2;
    kick(t0);
    wait_res(1);
    step(2);
    chk(res_v[0] == exp_v[0], "R11", "result after aborted burst", res_v[0], exp_v[0]);

    // R8 stop has priority over start
    clear_mon();
    start = 1'b1; stop = 1'b1;
    step(1);
    start = 1'b0; stop = 1'b0;
    chk(!busy, "R8", "start with stop", busy, 0);

    // R9 spurious valids during settling are ignored
    clear_mon();
    settle_code = 4'd5; avg_code = 4'd0; cur_n = 0; junk = 1'b1;
    kick(t0);
    wait_res(1);
    junk = 1'b0;
    step(2);
    chk(res_v[0] == exp_v[0], "R9", "result with early valids", res_v[0], exp_v[0]);

    // R10 start while busy and code changes mid-run are ignored
    clear_mon();
    settle_code = 4'd3; avg_code = 4'd2; cur_n = 2;
    kick(t0);
    step(2);
    settle_code = 4'd0; avg_code = 4'd0; cont_mode = 1'b1;
    start = 1'b1;
    step(1);
    start = 1'b0;
    wait_res(1);
    step(10);
    chk(mi == 1 && !busy, "R10", "single run kept", mi, 1);
    chk(ncv[0] == 4, "R10", "captured averaging code", ncv[0], 4);
    chk(first_conv[0] - t0 == settle_cyc(3) + 2, "R10", "captured settle code",
        first_conv[0] - t0, settle_cyc(3) + 2);
    cont_mode = 1'b0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule